// File: doc/BRIEF.md
# PLL Clock Switchover Sequencer

This block is a hardware sequencer that moves a chip's system clock from the internal oscillator, which drives the system after power-on reset, to a PLL fed by the main oscillator. A single start pulse runs an ordered bring-up. The sequencer powers the main oscillator and, in crystal mode, waits for the oscillator's raw ready flag. It then routes the main oscillator to the run-mode clock source, and optionally to the deep-sleep source. It presents the PLL frequency parameters, then the memory timing value. It waits for PLL lock, and finally commits the system divider and the use-PLL selection in one step.

Both waits are bounded by programmable cycle limits that share one down-counter. If the ready flag or the lock indication does not arrive within its limit, the sequence stops in an error state. The error flag holds until software issues the next start. The analog oscillator and PLL sit outside the block: they read its control outputs and return the two status inputs.

Top module: `clk_switch_seq`

## Requirements
- R1: After reset, `osc_noxtal` and `osc_pwrdn` are 1. `run_src` and `dsleep_src` are 0 (the internal oscillator code). All PLL, memory-timing and divider outputs are 0. `use_pll`, `memtim_upd`, `busy`, `done` and `error` are 0.
- R2: With `cfg_crystal`=0 (single-ended), the edge after the start edge clears `osc_noxtal` and leaves `osc_pwrdn` at 1. The sequence goes straight on, and `osc_ready_raw` has no effect.
- R3: With `cfg_crystal`=1, `osc_noxtal` and `osc_pwrdn` are both cleared on the edge after the start edge. The source select then waits until `osc_ready_raw` is sampled high, and happens on the edge after that sample.
- R4: Once the main oscillator is usable, the next edge sets `run_src` to 3 (main oscillator). `dsleep_src` becomes 3 on the same edge only when `cfg_dsleep_main`=1; otherwise it stays 0.
- R5: The four PLL parameters are presented one edge after the source select. `memtim` follows on the next edge, so `memtim` still holds its previous value while the new PLL parameters are already visible.
- R6: The lock wait loads `cfg_lock_limit` (T) into the timeout counter. Lock is accepted if it is sampled high in any of the first T+1 cycles of the wait; a lock sampled in the last of those cycles still wins. Without lock, `error` rises T+5 edges after the start edge in single-ended mode.
- R7: The crystal-ready wait loads `cfg_xtal_limit` (T). Without a ready flag, `error` rises T+2 edges after the start edge, and no source select or later step takes place.
- R8: The commit step sets `sysdiv`, `use_pll` and `done`, and pulses `memtim_upd` for one cycle, all on the same edge. That edge is the one after lock is accepted: 6 edges after start in single-ended mode when lock is already present.
- R9: `done` and `error` each hold until a start is accepted, and that start clears both on its edge. An error leaves `use_pll` unchanged.
- R10: A start pulse while `busy` is 1 is ignored: the running sequence finishes on its original schedule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sequencer clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse; accepted when not busy |
| cfg_crystal | input | 1 | 1 = crystal mode, 0 = single-ended input |
| cfg_dsleep_main | input | 1 | Also select the main oscillator for deep sleep |
| cfg_pll_q | input | Q_W | PLL Q divider value |
| cfg_pll_n | input | N_W | PLL N divider value |
| cfg_pll_mint | input | MINT_W | PLL integer multiplier |
| cfg_pll_mfrac | input | MFRAC_W | PLL fractional multiplier |
| cfg_memtim | input | MEMTIM_W | Memory timing value for the new clock |
| cfg_sysdiv | input | DIV_W | System clock divider |
| cfg_xtal_limit | input | TMO_W | Crystal-ready timeout in cycles |
| cfg_lock_limit | input | TMO_W | PLL lock timeout in cycles |
| osc_ready_raw | input | 1 | Main oscillator ready raw flag |
| pll_lock | input | 1 | PLL lock indication |
| osc_noxtal | output | 1 | 1 = main oscillator powered off |
| osc_pwrdn | output | 1 | 1 = crystal amplifier powered down |
| run_src | output | 4 | Run-mode clock source (0 internal, 3 main) |
| dsleep_src | output | 4 | Deep-sleep clock source (0 internal, 3 main) |
| pll_q | output | Q_W | Applied PLL Q value |
| pll_n | output | N_W | Applied PLL N value |
| pll_mint | output | MINT_W | Applied PLL integer multiplier |
| pll_mfrac | output | MFRAC_W | Applied PLL fractional multiplier |
| memtim | output | MEMTIM_W | Applied memory timing value |
| sysdiv | output | DIV_W | Applied system divider |
| use_pll | output | 1 | System clock taken from the PLL |
| memtim_upd | output | 1 | One-cycle memory timing update pulse |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | Sequence completed |
| error | output | 1 | Sequence aborted on a timeout |

## Verification
In either wait, the arrival of the status input (ready or lock) and the expiry of the timeout counter can fall in the same cycle. The bench provokes this by holding `pll_lock` low and raising it exactly for the sample at which the counter reaches zero. It judges the race won by the status input: `error` must stay 0 and `done` must rise one edge later. It also checks the neighbouring case, where no lock arrives and `error` rises on that same edge. A second collision, a start pulse arriving while the sequence is busy, is judged by `done` still rising on its original edge and staying set afterwards.

// File: rtl/clk_switch_pkg.sv
package clk_switch_pkg;

   localparam int SRC_W = 4;
   localparam logic [SRC_W-1:0] SRC_INTERNAL = 4'h0;
   localparam logic [SRC_W-1:0] SRC_MAIN     = 4'h3;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_MOSC,
      ST_XWAIT,
      ST_SRC,
      ST_PLL,
      ST_MEM,
      ST_LOCK,
      ST_COMMIT,
      ST_DONE,
      ST_ERR
   } seq_state_t;

endpackage

// File: rtl/cs_status_sync.sv
module cs_status_sync #(
   parameter int STAGES = 0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_pass
         assign q = d;
      end else begin : g_sync
         logic [STAGES-1:0] chain;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain <= '0;
            else if (STAGES == 1) chain <= d;
            else chain <= {chain[STAGES-2:0], d};
         end
         assign q = chain[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/cs_timer.sv
module cs_timer #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         run,
   output logic         zero
);
   logic [W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt <= '0;
      else if (load)              cnt <= load_val;
      else if (run && cnt != '0)  cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/cs_seq_fsm.sv
module cs_seq_fsm
   import clk_switch_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic crystal,
   input  logic ready,
   input  logic locked,
   input  logic tmr_zero,
   output logic start_acc,
   output logic busy,
   output logic act_mosc,
   output logic act_src,
   output logic act_pll,
   output logic act_mem,
   output logic act_commit,
   output logic err_set,
   output logic tmr_load,
   output logic tmr_sel_lock,
   output logic tmr_run
);
   seq_state_t state, state_nx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state <= ST_IDLE;
      else        state <= state_nx;
   end

   assign busy = !(state == ST_IDLE || state == ST_DONE || state == ST_ERR);
   assign start_acc = start && !busy;

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE, ST_DONE, ST_ERR: if (start) state_nx = ST_MOSC;
         ST_MOSC:   state_nx = crystal ? ST_XWAIT : ST_SRC;
         ST_XWAIT: begin
            if (ready)         state_nx = ST_SRC;
            else if (tmr_zero) state_nx = ST_ERR;
         end
         ST_SRC:    state_nx = ST_PLL;
         ST_PLL:    state_nx = ST_MEM;
         ST_MEM:    state_nx = ST_LOCK;
         ST_LOCK: begin
            if (locked)        state_nx = ST_COMMIT;
            else if (tmr_zero) state_nx = ST_ERR;
         end
         ST_COMMIT: state_nx = ST_DONE;
         default:   state_nx = ST_IDLE;
      endcase
   end

   assign act_mosc     = (state == ST_MOSC);
   assign act_src      = (state == ST_SRC);
   assign act_pll      = (state == ST_PLL);
   assign act_mem      = (state == ST_MEM);
   assign act_commit   = (state == ST_COMMIT);
   assign tmr_load     = (state == ST_MOSC && crystal) || (state == ST_MEM);
   assign tmr_sel_lock = (state == ST_MEM);
   assign tmr_run      = (state == ST_XWAIT) || (state == ST_LOCK);
   assign err_set      = (state == ST_XWAIT && !ready && tmr_zero) ||
                         (state == ST_LOCK && !locked && tmr_zero);
endmodule

// File: rtl/cs_out_regs.sv
module cs_out_regs
   import clk_switch_pkg::*;
#(
   parameter int Q_W      = 5,
   parameter int N_W      = 10,
   parameter int MINT_W   = 10,
   parameter int MFRAC_W  = 10,
   parameter int MEMTIM_W = 16,
   parameter int DIV_W    = 10
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start_acc,
   input  logic                act_mosc,
   input  logic                act_src,
   input  logic                act_pll,
   input  logic                act_mem,
   input  logic                act_commit,
   input  logic                err_set,
   input  logic                crystal,
   input  logic                dsleep_main,
   input  logic [Q_W-1:0]      cfg_q,
   input  logic [N_W-1:0]      cfg_n,
   input  logic [MINT_W-1:0]   cfg_mint,
   input  logic [MFRAC_W-1:0]  cfg_mfrac,
   input  logic [MEMTIM_W-1:0] cfg_memtim,
   input  logic [DIV_W-1:0]    cfg_sysdiv,
   output logic                noxtal,
   output logic                pwrdn,
   output logic [SRC_W-1:0]    run_src,
   output logic [SRC_W-1:0]    dsleep_src,
   output logic [Q_W-1:0]      q,
   output logic [N_W-1:0]      n,
   output logic [MINT_W-1:0]   mint,
   output logic [MFRAC_W-1:0]  mfrac,
   output logic [MEMTIM_W-1:0] memtim,
   output logic [DIV_W-1:0]    sysdiv,
   output logic                use_pll,
   output logic                memtim_upd,
   output logic                done,
   output logic                error
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         noxtal     <= 1'b1;
         pwrdn      <= 1'b1;
         run_src    <= SRC_INTERNAL;
         dsleep_src <= SRC_INTERNAL;
         q          <= '0;
         n          <= '0;
         mint       <= '0;
         mfrac      <= '0;
         memtim     <= '0;
         sysdiv     <= '0;
         use_pll    <= 1'b0;
         memtim_upd <= 1'b0;
         done       <= 1'b0;
         error      <= 1'b0;
      end else begin
         memtim_upd <= act_commit;
         if (start_acc) begin
            done  <= 1'b0;
            error <= 1'b0;
         end
         if (act_mosc) begin
            noxtal <= 1'b0;
            if (crystal) pwrdn <= 1'b0;
         end
         if (act_src) begin
            run_src <= SRC_MAIN;
            if (dsleep_main) dsleep_src <= SRC_MAIN;
         end
         if (act_pll) begin
            q     <= cfg_q;
            n     <= cfg_n;
            mint  <= cfg_mint;
            mfrac <= cfg_mfrac;
         end
         if (act_mem) memtim <= cfg_memtim;
         if (act_commit) begin
            sysdiv  <= cfg_sysdiv;
            use_pll <= 1'b1;
            done    <= 1'b1;
         end
         if (err_set) error <= 1'b1;
      end
   end
endmodule

// File: rtl/clk_switch_seq.sv
module clk_switch_seq
   import clk_switch_pkg::*;
#(
   parameter int Q_W         = 5,
   parameter int N_W         = 10,
   parameter int MINT_W      = 10,
   parameter int MFRAC_W     = 10,
   parameter int MEMTIM_W    = 16,
   parameter int DIV_W       = 10,
   parameter int TMO_W       = 16,
   parameter int SYNC_STAGES = 0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic                cfg_crystal,
   input  logic                cfg_dsleep_main,
   input  logic [Q_W-1:0]      cfg_pll_q,
   input  logic [N_W-1:0]      cfg_pll_n,
   input  logic [MINT_W-1:0]   cfg_pll_mint,
   input  logic [MFRAC_W-1:0]  cfg_pll_mfrac,
   input  logic [MEMTIM_W-1:0] cfg_memtim,
   input  logic [DIV_W-1:0]    cfg_sysdiv,
   input  logic [TMO_W-1:0]    cfg_xtal_limit,
   input  logic [TMO_W-1:0]    cfg_lock_limit,
   input  logic                osc_ready_raw,
   input  logic                pll_lock,
   output logic                osc_noxtal,
   output logic                osc_pwrdn,
   output logic [3:0]          run_src,
   output logic [3:0]          dsleep_src,
   output logic [Q_W-1:0]      pll_q,
   output logic [N_W-1:0]      pll_n,
   output logic [MINT_W-1:0]   pll_mint,
   output logic [MFRAC_W-1:0]  pll_mfrac,
   output logic [MEMTIM_W-1:0] memtim,
   output logic [DIV_W-1:0]    sysdiv,
   output logic                use_pll,
   output logic                memtim_upd,
   output logic                busy,
   output logic                done,
   output logic                error
);
   generate
      if (TMO_W < 2 || TMO_W > 32) begin : g_bad_tmo
         $error("clk_switch_seq: TMO_W must lie in 2..32");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 4) begin : g_bad_sync
         $error("clk_switch_seq: SYNC_STAGES must lie in 0..4");
      end
      if (Q_W < 1 || N_W < 1 || MINT_W < 1 || MFRAC_W < 1 ||
          MEMTIM_W < 1 || DIV_W < 1) begin : g_bad_width
         $error("clk_switch_seq: field widths must be positive");
      end
   endgenerate

   logic ready_s, lock_s;
   logic start_acc, act_mosc, act_src, act_pll, act_mem, act_commit, err_set;
   logic tmr_load, tmr_sel_lock, tmr_run, tmr_zero;
   logic [TMO_W-1:0] tmr_val;

   cs_status_sync #(.STAGES(SYNC_STAGES)) i_sync_ready (
      .clk(clk), .rst_n(rst_n), .d(osc_ready_raw), .q(ready_s));

   cs_status_sync #(.STAGES(SYNC_STAGES)) i_sync_lock (
      .clk(clk), .rst_n(rst_n), .d(pll_lock), .q(lock_s));

   assign tmr_val = tmr_sel_lock ? cfg_lock_limit : cfg_xtal_limit;

   cs_timer #(.W(TMO_W)) i_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
      .run(tmr_run), .zero(tmr_zero));

   cs_seq_fsm i_fsm (
      .clk(clk), .rst_n(rst_n), .start(start), .crystal(cfg_crystal),
      .ready(ready_s), .locked(lock_s), .tmr_zero(tmr_zero),
      .start_acc(start_acc), .busy(busy), .act_mosc(act_mosc),
      .act_src(act_src), .act_pll(act_pll), .act_mem(act_mem),
      .act_commit(act_commit), .err_set(err_set), .tmr_load(tmr_load),
      .tmr_sel_lock(tmr_sel_lock), .tmr_run(tmr_run));

   cs_out_regs #(
      .Q_W(Q_W), .N_W(N_W), .MINT_W(MINT_W), .MFRAC_W(MFRAC_W),
      .MEMTIM_W(MEMTIM_W), .DIV_W(DIV_W)
   ) i_regs (
      .clk(clk), .rst_n(rst_n), .start_acc(start_acc), .act_mosc(act_mosc),
      .act_src(act_src), .act_pll(act_pll), .act_mem(act_mem),
      .act_commit(act_commit), .err_set(err_set), .crystal(cfg_crystal),
      .dsleep_main(cfg_dsleep_main), .cfg_q(cfg_pll_q), .cfg_n(cfg_pll_n),
      .cfg_mint(cfg_pll_mint), .cfg_mfrac(cfg_pll_mfrac),
      .cfg_memtim(cfg_memtim), .cfg_sysdiv(cfg_sysdiv),
      .noxtal(osc_noxtal), .pwrdn(osc_pwrdn), .run_src(run_src),
      .dsleep_src(dsleep_src), .q(pll_q), .n(pll_n), .mint(pll_mint),
      .mfrac(pll_mfrac), .memtim(memtim), .sysdiv(sysdiv),
      .use_pll(use_pll), .memtim_upd(memtim_upd), .done(done),
      .error(error));
endmodule

// File: rtl/cs_seq_checker.sv
module cs_seq_checker (
   input logic       clk,
   input logic       rst_n,
   input logic       start,
   input logic       osc_noxtal,
   input logic       osc_pwrdn,
   input logic [3:0] run_src,
   input logic       use_pll,
   input logic       memtim_upd,
   input logic       busy,
   input logic       done,
   input logic       error
);
   // R3: the crystal amplifier is never enabled while the oscillator is off
   assert_pwrdn_after_noxtal_R3: assert property (@(posedge clk) disable iff (!rst_n)
      !osc_pwrdn |-> !osc_noxtal);

   // R4: main source is selected only once the main oscillator is powered
   assert_src_needs_mosc_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (run_src == 4'h3) |-> !osc_noxtal);

   // R8: use-PLL switches on together with done
   assert_commit_with_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(use_pll) |-> $rose(done));

   // R8: the memory timing update pulse lasts one cycle and comes with the commit
   assert_upd_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
      memtim_upd |=> !memtim_upd);

   assert_upd_with_pll_R8: assert property (@(posedge clk) disable iff (!rst_n)
      memtim_upd |-> (use_pll && done));

   // R9: error holds until a start
   assert_error_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (error && !start) |=> error);

   // R9: done holds until a start
   assert_done_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !start) |=> done);

   // R9: an error leaves use_pll where it was
   assert_error_keeps_pll_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(error) |-> $stable(use_pll));

   // R9: an accepted start clears both flags
   assert_start_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |=> (!done && !error));

   // R10: while busy, no outcome flag is shown
   assert_busy_no_flags_R10: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (!done && !error));
endmodule

bind clk_switch_seq cs_seq_checker i_cs_seq_checker (
   .clk(clk), .rst_n(rst_n), .start(start), .osc_noxtal(osc_noxtal),
   .osc_pwrdn(osc_pwrdn), .run_src(run_src), .use_pll(use_pll),
   .memtim_upd(memtim_upd), .busy(busy), .done(done), .error(error));

// File: tb/test_clk_switch_seq.sv
`timescale 1ns/1ps
module test_clk_switch_seq;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        cfg_crystal = 1'b0;
   logic        cfg_dsleep_main = 1'b0;
   logic [4:0]  cfg_pll_q = 5'h0B;
   logic [9:0]  cfg_pll_n = 10'h155;
   logic [9:0]  cfg_pll_mint = 10'h1E0;
   logic [9:0]  cfg_pll_mfrac = 10'h2A3;
   logic [15:0] cfg_memtim = 16'hC3A5;
   logic [9:0]  cfg_sysdiv = 10'h003;
   logic [15:0] cfg_xtal_limit = 16'd10;
   logic [15:0] cfg_lock_limit = 16'd10;
   logic        osc_ready_raw = 1'b0;
   logic        pll_lock = 1'b0;
   logic        osc_noxtal, osc_pwrdn, use_pll, memtim_upd, busy, done, error;
   logic [3:0]  run_src, dsleep_src;
   logic [4:0]  pll_q;
   logic [9:0]  pll_n, pll_mint, pll_mfrac, sysdiv;
   logic [15:0] memtim;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   clk_switch_seq i_clk_switch_seq (
      .clk(clk), .rst_n(rst_n), .start(start), .cfg_crystal(cfg_crystal),
      .cfg_dsleep_main(cfg_dsleep_main), .cfg_pll_q(cfg_pll_q),
      .cfg_pll_n(cfg_pll_n), .cfg_pll_mint(cfg_pll_mint),
      .cfg_pll_mfrac(cfg_pll_mfrac), .cfg_memtim(cfg_memtim),
      .cfg_sysdiv(cfg_sysdiv), .cfg_xtal_limit(cfg_xtal_limit),
      .cfg_lock_limit(cfg_lock_limit), .osc_ready_raw(osc_ready_raw),
      .pll_lock(pll_lock), .osc_noxtal(osc_noxtal), .osc_pwrdn(osc_pwrdn),
      .run_src(run_src), .dsleep_src(dsleep_src), .pll_q(pll_q),
      .pll_n(pll_n), .pll_mint(pll_mint), .pll_mfrac(pll_mfrac),
      .memtim(memtim), .sysdiv(sysdiv), .use_pll(use_pll),
      .memtim_upd(memtim_upd), .busy(busy), .done(done), .error(error));

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      start = 1'b0;
      osc_ready_raw = 1'b0;
      pll_lock = 1'b0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   // leaves time just after the edge that samples start (edge 0)
   task automatic pulse_start();
      @(negedge clk);
      start = 1'b1;
      @(posedge clk);
      #1 start = 1'b0;
   endtask

   task automatic edges(input int n);
      repeat (n) begin
         @(posedge clk);
         #1;
      end
   endtask

   task automatic t_reset();
      do_reset();
      #1;
      check("R1 noxtal", osc_noxtal, 1);
      check("R1 pwrdn", osc_pwrdn, 1);
      check("R1 run_src", run_src, 0);
      check("R1 dsleep_src", dsleep_src, 0);
      check("R1 pll_q", pll_q, 0);
      check("R1 memtim", memtim, 0);
      check("R1 sysdiv", sysdiv, 0);
      check("R1 flags", {use_pll, memtim_upd, busy, done, error}, 0);
   endtask

   task automatic t_single();
      do_reset();
      cfg_crystal = 1'b0;
      cfg_dsleep_main = 1'b1;
      pll_lock = 1'b1;
      osc_ready_raw = 1'b0;
      pulse_start();
      check("R10 busy after start", busy, 1);
      edges(1);
      check("R2 noxtal cleared", osc_noxtal, 0);
      check("R2 pwrdn kept", osc_pwrdn, 1);
      edges(1);
      check("R4 run_src main", run_src, 3);
      check("R4 dsleep main", dsleep_src, 3);
      edges(1);
      check("R5 pll_q", pll_q, cfg_pll_q);
      check("R5 pll_n", pll_n, cfg_pll_n);
      check("R5 pll_mint", pll_mint, cfg_pll_mint);
      check("R5 pll_mfrac", pll_mfrac, cfg_pll_mfrac);
      check("R5 memtim not yet", memtim, 0);
      edges(1);
      check("R5 memtim", memtim, cfg_memtim);
      edges(1);
      check("R8 not done early", {done, use_pll}, 0);
      edges(1);
      check("R8 done", done, 1);
      check("R8 use_pll", use_pll, 1);
      check("R8 memtim_upd", memtim_upd, 1);
      check("R8 sysdiv", sysdiv, cfg_sysdiv);
      check("R2 pwrdn at end", osc_pwrdn, 1);
      edges(1);
      check("R8 upd one cycle", memtim_upd, 0);
      check("R9 done held", done, 1);
   endtask

   task automatic t_crystal_ok();
      do_reset();
      cfg_crystal = 1'b1;
      cfg_dsleep_main = 1'b0;
      cfg_xtal_limit = 16'd10;
      pll_lock = 1'b1;
      pulse_start();
      edges(1);
      check("R3 noxtal", osc_noxtal, 0);
      check("R3 pwrdn", osc_pwrdn, 0);
      edges(3);
      check("R3 waiting src", run_src, 0);
      osc_ready_raw = 1'b1;
      edges(1);
      check("R3 src after ready sample", run_src, 0);
      edges(1);
      check("R3 src selected", run_src, 3);
      check("R4 dsleep untouched", dsleep_src, 0);
      edges(3);
      check("R3 not done yet", done, 0);
      edges(1);
      check("R3 done", done, 1);
   endtask

   task automatic t_xtal_timeout();
      do_reset();
      cfg_crystal = 1'b1;
      cfg_xtal_limit = 16'd6;
      pll_lock = 1'b1;
      pulse_start();
      edges(7);
      check("R7 no error before limit", error, 0);
      edges(1);
      check("R7 error", error, 1);
      check("R7 no src select", run_src, 0);
      check("R7 not busy", busy, 0);
      edges(4);
      check("R7 no later step", {done, use_pll}, 0);
   endtask

   task automatic t_lock_timeout();
      do_reset();
      cfg_crystal = 1'b0;
      cfg_lock_limit = 16'd4;
      pll_lock = 1'b0;
      pulse_start();
      edges(8);
      check("R6 no error before limit", error, 0);
      edges(1);
      check("R6 error", error, 1);
      check("R9 use_pll kept", use_pll, 0);
      edges(5);
      check("R9 error held", error, 1);
      pll_lock = 1'b1;
      pulse_start();
      check("R9 start clears error", error, 0);
      edges(6);
      check("R9 rerun done", done, 1);
   endtask

   task automatic t_lock_race();
      do_reset();
      cfg_crystal = 1'b0;
      cfg_lock_limit = 16'd4;
      pll_lock = 1'b0;
      pulse_start();
      edges(8);
      pll_lock = 1'b1;
      edges(1);
      check("R6 last-cycle lock wins", error, 0);
      edges(1);
      check("R6 done after race", done, 1);
      check("R6 no error after race", error, 0);
   endtask

   task automatic t_busy_start();
      do_reset();
      cfg_crystal = 1'b0;
      pll_lock = 1'b1;
      pulse_start();
      edges(2);
      pulse_start();
      edges(3);
      check("R10 done on schedule", done, 1);
      edges(3);
      check("R10 no restart", done, 1);
      check("R10 idle", busy, 0);
      pulse_start();
      check("R9 start clears done", done, 0);
      check("R9 restart busy", busy, 1);
   endtask

   initial begin
      t_reset();
      t_single();
      t_crystal_ok();
      t_xtal_timeout();
      t_lock_timeout();
      t_lock_race();
      t_busy_start();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      #800000;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule